// File: doc/BRIEF.md
# Burst Waveform Playback Generator

This block streams a waveform held in an on-chip sample table to a 14-bit DAC. A fixed-point phase pointer walks the table. Its integer bits address the table and its 16 fractional bits let the step be a fraction of an entry, so one stored period can be played at many rates. Each sample read from the table is multiplied by a gain, where 0x2000 means unity. An offset is then added and the result is clamped to the signed 14-bit range. A wrap point and a start position bound the part of the table that is played. A mode bit selects how the pointer behaves when it reaches the wrap point: it can keep the overshoot for seamless fractional periods, or it can jump back to the start position.

Playback begins on a trigger pulse. In continuous mode it runs until the next trigger. In burst mode it stops after a programmed number of table periods. It then rests for a gap measured in microseconds and replays, for a programmed number of bursts in total. During gaps and when idle the block emits the offset value. All settings are written through a simple word-addressed register port. The phase pointer can be read back and overwritten through the same port. The table is loaded through its own write port.

Samples leave on a valid/ready stream. A sample is offered as soon as the output register holds one and stays offered until taken. While `dac_valid` is high and `dac_ready` is low, `dac_data` does not change and the phase pointer does not move. The pointer advances only when a sample is accepted, so the consumer's acceptance rate is the sample clock.

Top module: `awg_burst_player`

## Requirements
- R1: While reset is held, `dac_valid` is 0, all registers read 0 and the phase pointer is 0. On the first clock after reset, a sample equal to the offset (0) is offered.
- R2: During playback each offered sample is floor(s*g/8192)+o. Here s is the signed 14-bit table entry, g is the unsigned 14-bit gain (register 1) and o is the signed 14-bit offset (register 2), both in two's complement.
- R3: The output of R2 is clamped to the range -8192..8191.
- R4: The table entry used is the pointer shifted right by 16. Each accepted sample advances the pointer by the step (register 3).
- R5: When pointer+step is at or above the wrap point (register 4), the next pointer is pointer+step-wrap if control bit 0 is 1, and the start position (register 5) if control bit 0 is 0.
- R6: A trigger pulse, in any state, loads the start position and begins playback. The sample that belongs to the start position is offered on the second clock after the trigger.
- R7: With control bit 1 set, a burst ends at the N-th wrap event, where N is register 7 and 0 counts as 1. After M bursts, where M is register 8 and 0 counts as 1, the block goes idle and emits the offset.
- R8: Between bursts, the block emits the offset for register 9 times CLK_MHZ clocks. It then resumes from the start position. A gap of 0 resumes at once.
- R9: Register 6 reads the live phase pointer. A write to register 6 replaces the pointer.
- R10: While `dac_valid` is 1 and `dac_ready` is 0, `dac_data` holds and no sample is skipped.
- R11: With control bit 1 clear, playback continues through any number of wrap events.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register write address |
| reg_wdata | input | 32 | Register write data |
| reg_raddr | input | 4 | Register read address |
| reg_rdata | output | 32 | Register read data (combinational) |
| tbl_we | input | 1 | Table write strobe |
| tbl_addr | input | ADDR_W | Table write address |
| tbl_wdata | input | 14 | Table write data |
| trig | input | 1 | Start trigger pulse |
| dac_valid | output | 1 | Sample offered |
| dac_ready | input | 1 | Consumer accepts sample |
| dac_data | output | 14 | Signed sample to DAC |

## Verification
The bench builds the block with a 1024-entry table (ADDR_W=10) and CLK_MHZ=4. With these values a one-microsecond gap lasts four clocks, so a whole two-burst sequence, including its gap and the return to idle, fits in about twenty samples and can be compared sample by sample. The small table also lets the bench load every entry with a linear ramp. This makes each expected sample a simple function of its address, and the gain and offset vectors can reach both clamp limits.

// File: rtl/awg_pkg.sv
package awg_pkg;
  localparam int SMP_W      = 14;
  localparam int GAIN_SHIFT = 13;
  localparam int BUS_W      = 32;
  localparam int RA_W       = 4;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_PLAY = 2'd1,
    ST_GAP  = 2'd2
  } seq_st_t;

  localparam logic [RA_W-1:0] RA_CTRL  = 4'd0;
  localparam logic [RA_W-1:0] RA_GAIN  = 4'd1;
  localparam logic [RA_W-1:0] RA_OFFS  = 4'd2;
  localparam logic [RA_W-1:0] RA_STEP  = 4'd3;
  localparam logic [RA_W-1:0] RA_WRAP  = 4'd4;
  localparam logic [RA_W-1:0] RA_START = 4'd5;
  localparam logic [RA_W-1:0] RA_PTR   = 4'd6;
  localparam logic [RA_W-1:0] RA_NCYC  = 4'd7;
  localparam logic [RA_W-1:0] RA_NREP  = 4'd8;
  localparam logic [RA_W-1:0] RA_GAP   = 4'd9;
endpackage

// File: rtl/awg_phase.sv
module awg_phase #(
  parameter int PW = 26
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          load_start,
  input  logic          sw_we,
  input  logic          adv,
  input  logic          keep,
  input  logic [PW-1:0] sw_val,
  input  logic [PW-1:0] step,
  input  logic [PW-1:0] wrap,
  input  logic [PW-1:0] start,
  output logic [PW-1:0] ptr,
  output logic          wrap_evt
);
  logic [PW:0] sum;
  logic [PW:0] over;

  assign sum      = {1'b0, ptr} + {1'b0, step};
  assign over     = sum - {1'b0, wrap};
  assign wrap_evt = adv && (sum >= {1'b0, wrap});

  always_ff @(posedge clk) begin
    if (rst)             ptr <= '0;
    else if (load_start) ptr <= start;
    else if (sw_we)      ptr <= sw_val;
    else if (wrap_evt)   ptr <= keep ? over[PW-1:0] : start;
    else if (adv)        ptr <= sum[PW-1:0];
  end

  assert_trig_loads_R6: assert property (@(posedge clk) disable iff (rst)
    load_start |=> ptr == $past(start));

  assert_wrap_restart_R5: assert property (@(posedge clk) disable iff (rst)
    (wrap_evt && !keep && !load_start && !sw_we) |=> ptr == $past(start));
endmodule

// File: rtl/awg_seq.sv
module awg_seq
  import awg_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int CLK_MHZ = 50
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             trig,
  input  logic             burst_en,
  input  logic             wrap_evt,
  input  logic             fire,
  input  logic [CNT_W-1:0] ncyc,
  input  logic [CNT_W-1:0] nrep,
  input  logic [CNT_W-1:0] gap,
  output seq_st_t          st,
  output logic             adv,
  output logic             restart
);
  localparam int PRE_W = (CLK_MHZ > 1) ? $clog2(CLK_MHZ) : 1;
  localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(CLK_MHZ - 1);

  logic [CNT_W-1:0] cyc_cnt, rep_cnt, gap_cnt;
  logic [PRE_W-1:0] pre;
  logic cyc_last, rep_last, burst_end, tick;

  always_comb begin
    cyc_last  = ({1'b0, cyc_cnt} + (CNT_W+1)'(1)) >= {1'b0, ncyc};
    rep_last  = ({1'b0, rep_cnt} + (CNT_W+1)'(1)) >= {1'b0, nrep};
    tick      = (pre == PRE_LAST);
    adv       = (st == ST_PLAY) && fire;
    burst_end = burst_en && wrap_evt && cyc_last;
    restart   = trig || (burst_end && !rep_last);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE; cyc_cnt <= '0; rep_cnt <= '0; gap_cnt <= '0; pre <= '0;
    end else if (trig) begin
      st <= ST_PLAY; cyc_cnt <= '0; rep_cnt <= '0;
    end else begin
      case (st)
        ST_PLAY: begin
          if (burst_end) begin
            cyc_cnt <= '0;
            if (rep_last) st <= ST_IDLE;
            else begin
              rep_cnt <= rep_cnt + 1'b1;
              if (gap != '0) begin
                st <= ST_GAP; gap_cnt <= gap; pre <= '0;
              end
            end
          end else if (burst_en && wrap_evt) begin
            cyc_cnt <= cyc_cnt + 1'b1;
          end
        end
        ST_GAP: begin
          if (tick) begin
            pre     <= '0;
            gap_cnt <= gap_cnt - 1'b1;
            if (gap_cnt == CNT_W'(1)) st <= ST_PLAY;
          end else begin
            pre <= pre + 1'b1;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assert_last_burst_idles_R7: assert property (@(posedge clk) disable iff (rst)
    (burst_end && rep_last && !trig) |=> (st == ST_IDLE && !adv));
endmodule

// File: rtl/awg_scale.sv
module awg_scale
  import awg_pkg::*;
(
  input  logic [SMP_W-1:0] sample,
  input  logic [SMP_W-1:0] gain,
  input  logic [SMP_W-1:0] offs,
  output logic [SMP_W-1:0] res
);
  localparam int MW = 2*SMP_W + 1;
  localparam logic signed [MW:0] MAXV = (MW+1)'((1 << (SMP_W-1)) - 1);
  localparam logic signed [MW:0] MINV = -MAXV - (MW+1)'(1);

  logic signed [MW-1:0] a_x, b_x, prod, shr;
  logic signed [MW:0]   total;

  always_comb begin
    a_x   = MW'($signed(sample));
    b_x   = $signed(MW'(gain));
    prod  = a_x * b_x;
    shr   = prod >>> GAIN_SHIFT;
    total = (MW+1)'(shr) + (MW+1)'($signed(offs));
    if (total > MAXV)      res = MAXV[SMP_W-1:0];
    else if (total < MINV) res = MINV[SMP_W-1:0];
    else                   res = total[SMP_W-1:0];
  end
endmodule

// File: rtl/awg_burst_player.sv
module awg_burst_player
  import awg_pkg::*;
#(
  parameter int ADDR_W  = 10,
  parameter int FRAC_W  = 16,
  parameter int CNT_W   = 16,
  parameter int CLK_MHZ = 50
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [RA_W-1:0]   reg_addr,
  input  logic [BUS_W-1:0]  reg_wdata,
  input  logic [RA_W-1:0]   reg_raddr,
  output logic [BUS_W-1:0]  reg_rdata,
  input  logic              tbl_we,
  input  logic [ADDR_W-1:0] tbl_addr,
  input  logic [SMP_W-1:0]  tbl_wdata,
  input  logic              trig,
  output logic              dac_valid,
  input  logic              dac_ready,
  output logic [SMP_W-1:0]  dac_data
);
  localparam int PW    = ADDR_W + FRAC_W;
  localparam int DEPTH = 1 << ADDR_W;
  localparam logic [SMP_W-1:0] UNITY = SMP_W'(1 << GAIN_SHIFT);

  logic [1:0]       ctrl;
  logic [SMP_W-1:0] gain, offs;
  logic [PW-1:0]    step, wrap, start, ptr;
  logic [CNT_W-1:0] ncyc, nrep, gap;
  logic             ptr_we, fire, adv, restart, wrap_evt;
  seq_st_t          st;
  logic [SMP_W-1:0] mem [DEPTH];
  logic [SMP_W-1:0] sample, scaled;

  assign ptr_we = reg_we && (reg_addr == RA_PTR);
  assign fire   = !dac_valid || dac_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl <= '0; gain <= '0; offs <= '0; step <= '0; wrap <= '0;
      start <= '0; ncyc <= '0; nrep <= '0; gap <= '0;
    end else if (reg_we) begin
      case (reg_addr)
        RA_CTRL:  ctrl  <= reg_wdata[1:0];
        RA_GAIN:  gain  <= reg_wdata[SMP_W-1:0];
        RA_OFFS:  offs  <= reg_wdata[SMP_W-1:0];
        RA_STEP:  step  <= reg_wdata[PW-1:0];
        RA_WRAP:  wrap  <= reg_wdata[PW-1:0];
        RA_START: start <= reg_wdata[PW-1:0];
        RA_NCYC:  ncyc  <= reg_wdata[CNT_W-1:0];
        RA_NREP:  nrep  <= reg_wdata[CNT_W-1:0];
        RA_GAP:   gap   <= reg_wdata[CNT_W-1:0];
        default: ;
      endcase
    end
  end

  always_comb begin
    case (reg_raddr)
      RA_CTRL:  reg_rdata = BUS_W'(ctrl);
      RA_GAIN:  reg_rdata = BUS_W'(gain);
      RA_OFFS:  reg_rdata = BUS_W'(offs);
      RA_STEP:  reg_rdata = BUS_W'(step);
      RA_WRAP:  reg_rdata = BUS_W'(wrap);
      RA_START: reg_rdata = BUS_W'(start);
      RA_PTR:   reg_rdata = BUS_W'(ptr);
      RA_NCYC:  reg_rdata = BUS_W'(ncyc);
      RA_NREP:  reg_rdata = BUS_W'(nrep);
      RA_GAP:   reg_rdata = BUS_W'(gap);
      default:  reg_rdata = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (tbl_we) mem[tbl_addr] <= tbl_wdata;
  end
  assign sample = mem[ptr[PW-1:FRAC_W]];

  awg_phase #(.PW(PW)) u_phase (
    .clk(clk), .rst(rst), .load_start(restart), .sw_we(ptr_we), .adv(adv),
    .keep(ctrl[0]), .sw_val(reg_wdata[PW-1:0]), .step(step), .wrap(wrap),
    .start(start), .ptr(ptr), .wrap_evt(wrap_evt)
  );

  awg_seq #(.CNT_W(CNT_W), .CLK_MHZ(CLK_MHZ)) u_seq (
    .clk(clk), .rst(rst), .trig(trig), .burst_en(ctrl[1]), .wrap_evt(wrap_evt),
    .fire(fire), .ncyc(ncyc), .nrep(nrep), .gap(gap), .st(st), .adv(adv),
    .restart(restart)
  );

  awg_scale u_scale (.sample(sample), .gain(gain), .offs(offs), .res(scaled));

  always_ff @(posedge clk) begin
    if (rst) begin
      dac_valid <= 1'b0;
      dac_data  <= '0;
    end else if (fire) begin
      dac_valid <= 1'b1;
      dac_data  <= (st == ST_PLAY) ? scaled : offs;
    end
  end

  assert_hold_R10: assert property (@(posedge clk) disable iff (rst)
    (dac_valid && !dac_ready) |=> (dac_valid && $stable(dac_data)));

  assert_unity_gain_R2: assert property (@(posedge clk) disable iff (rst)
    (st == ST_PLAY && fire && gain == UNITY && offs == '0) |=> dac_data == $past(sample));

  assert_gap_frozen_R8: assert property (@(posedge clk) disable iff (rst)
    (st == ST_GAP && $past(st == ST_GAP) && !$past(trig) && !$past(ptr_we)) |-> $stable(ptr));
endmodule

// File: tb/sim_awg_burst_player.sv
module sim_awg_burst_player;
  localparam int ADDR_W = 10;
  localparam int CLKM   = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [3:0]  reg_raddr = '0;
  logic [31:0] reg_rdata;
  logic        tbl_we = 1'b0;
  logic [ADDR_W-1:0] tbl_addr = '0;
  logic [13:0] tbl_wdata = '0;
  logic        trig = 1'b0;
  logic        dac_valid;
  logic        dac_ready = 1'b1;
  logic [13:0] dac_data;
  int n_chk = 0;
  int n_bad = 0;

  always #10 clk = ~clk;

  awg_burst_player #(.ADDR_W(ADDR_W), .FRAC_W(16), .CNT_W(16), .CLK_MHZ(CLKM)) u0 (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .reg_raddr(reg_raddr), .reg_rdata(reg_rdata), .tbl_we(tbl_we), .tbl_addr(tbl_addr),
    .tbl_wdata(tbl_wdata), .trig(trig), .dac_valid(dac_valid), .dac_ready(dac_ready),
    .dac_data(dac_data)
  );

  typedef struct packed {
    logic [9:0]  a;
    logic [13:0] g;
    logic [13:0] o;
    logic [13:0] e;
  } vec_t;

  localparam vec_t VECS [8] = '{
    '{10'd512,  14'h2000, 14'h0000, 14'h0000},
    '{10'd612,  14'h2000, 14'd100,  14'd900},
    '{10'd612,  14'h1000, 14'h3FCE, 14'd350},
    '{10'd0,    14'h3FFF, 14'h0000, 14'h2000},
    '{10'd0,    14'h3FFF, 14'h3F9C, 14'h2000},
    '{10'd1023, 14'h3FFF, 14'd100,  14'h1FFF},
    '{10'd1,    14'd3,    14'h0000, 14'h3FFE},
    '{10'd513,  14'h2000, 14'd8000, 14'h1F48}
  };

  function automatic logic [13:0] ramp(input int a);
    return 14'(a*8 - 4096);
  endfunction

  function automatic logic [13:0] model(input int a, input int g, input int o);
    int s, q;
    s = a*8 - 4096;
    q = ((s * g) >>> 13) + o;
    if (q > 8191) q = 8191;
    if (q < -8192) q = -8192;
    return 14'(q);
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic pulse_trig();
    trig = 1'b1;
    @(negedge clk);
    trig = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [13:0] exp_seq [20];
    int k;
    // R1: reset state
    repeat (3) @(negedge clk);
    reg_raddr = 4'd6;
    #1;
    check("R1 valid in reset", 32'(dac_valid), 32'd0);
    check("R1 pointer in reset", reg_rdata, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    check("R1 first sample valid", 32'(dac_valid), 32'd1);
    check("R1 first sample value", 32'(dac_data), 32'd0);

    for (int a = 0; a < (1 << ADDR_W); a++) begin
      tbl_we = 1'b1; tbl_addr = ADDR_W'(a); tbl_wdata = ramp(a);
      @(negedge clk);
    end
    tbl_we = 1'b0;

    // R2/R3 vector walk
    wr(4'd0, 32'd0);
    wr(4'd3, 32'd0);
    wr(4'd4, 32'(1000 << 16));
    foreach (VECS[i]) begin
      wr(4'd1, 32'(VECS[i].g));
      wr(4'd2, 32'(VECS[i].o));
      wr(4'd5, 32'(VECS[i].a) << 16);
      pulse_trig();
      @(negedge clk);
      check("R2/R3 gain-offset-clamp vector", 32'(dac_data), 32'(VECS[i].e));
    end

    // R4: fractional step 1.5
    wr(4'd1, 32'h2000);
    wr(4'd2, 32'd0);
    wr(4'd5, 32'(10 << 16));
    wr(4'd3, 32'h18000);
    pulse_trig();
    @(negedge clk); check("R4 step 1.5 at 10", 32'(dac_data), 32'(ramp(10)));
    @(negedge clk); check("R4 step 1.5 at 11", 32'(dac_data), 32'(ramp(11)));
    @(negedge clk); check("R4 step 1.5 at 13", 32'(dac_data), 32'(ramp(13)));
    @(negedge clk); check("R4 step 1.5 at 14", 32'(dac_data), 32'(ramp(14)));
    @(negedge clk); check("R4 step 1.5 at 16", 32'(dac_data), 32'(ramp(16)));

    // R5: keep-overshoot wrap
    wr(4'd0, 32'd1);
    wr(4'd5, 32'd0);
    wr(4'd3, 32'(3 << 16));
    wr(4'd4, 32'(10 << 16));
    pulse_trig();
    k = 0;
    foreach (exp_seq[i]) exp_seq[i] = '0;
    exp_seq[0] = ramp(0); exp_seq[1] = ramp(3); exp_seq[2] = ramp(6); exp_seq[3] = ramp(9);
    exp_seq[4] = ramp(2); exp_seq[5] = ramp(5); exp_seq[6] = ramp(8); exp_seq[7] = ramp(1);
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      check("R5 keep-overshoot wrap", 32'(dac_data), 32'(exp_seq[i]));
    end

    // R5/R11: restart wrap, continuous over several periods
    wr(4'd0, 32'd0);
    pulse_trig();
    for (int i = 0; i < 10; i++) begin
      @(negedge clk);
      check("R5/R11 restart wrap continuous", 32'(dac_data), 32'(ramp((i % 4) * 3)));
    end

    // R10: back-pressure
    wr(4'd3, 32'(1 << 16));
    wr(4'd4, 32'(1000 << 16));
    wr(4'd5, 32'(100 << 16));
    pulse_trig();
    @(negedge clk);
    check("R10 first sample", 32'(dac_data), 32'(ramp(100)));
    dac_ready = 1'b0;
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      check("R10 held under back-pressure", 32'(dac_data), 32'(ramp(100)));
    end
    dac_ready = 1'b1;
    @(negedge clk);
    check("R10 no sample skipped", 32'(dac_data), 32'(ramp(101)));

    // R7/R8: two bursts of two periods, 1 us gap
    wr(4'd2, 32'd77);
    wr(4'd5, 32'd0);
    wr(4'd3, 32'(2 << 16));
    wr(4'd4, 32'(6 << 16));
    wr(4'd7, 32'd2);
    wr(4'd8, 32'd2);
    wr(4'd9, 32'd1);
    wr(4'd0, 32'd2);
    pulse_trig();
    for (int i = 0; i < 19; i++) begin
      logic [13:0] e;
      if (i < 6)       e = model((i % 3) * 2, 32'h2000, 77);
      else if (i < 10) e = 14'd77;
      else if (i < 16) e = model(((i - 10) % 3) * 2, 32'h2000, 77);
      else             e = 14'd77;
      @(negedge clk);
      check((i >= 6 && i < 10) ? "R8 gap emits offset" : "R7 burst sequence",
            32'(dac_data), 32'(e));
    end

    // R6: retrigger from idle
    pulse_trig();
    @(negedge clk);
    check("R6 retrigger from idle", 32'(dac_data), 32'(model(0, 32'h2000, 77)));

    // R9: pointer write and readback while idle
    repeat (20) @(negedge clk);
    wr(4'd6, 32'h12345);
    reg_raddr = 4'd6;
    #1;
    check("R9 pointer readback", reg_rdata, 32'h12345);
    @(negedge clk);
    check("R9 pointer idle hold", reg_rdata, 32'h12345);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule